// File: doc/BRIEF.md
# Programmable Sound Generator Tone, Noise and Mixer Core

This core is the sound-producing half of a programmable sound generator. It runs three square-wave tone oscillators and one shared pseudo-random noise source from a common master tick. It gates each channel's amplitude by that channel's tone bit and the shared noise bit, under active-low enables. The result is three 5-bit digital amplitudes for a downstream converter. Each channel takes its amplitude from either a 4-bit fixed level or a 5-bit envelope value that an external envelope block supplies.

The master tick is the input clock enable, or every second enable when the rate select is low. A shared prescaler divides the master tick by 8 for the tone counters and by 16 for the noise counter. Software-visible registers sit outside this core: it sees the period, enable and level fields as plain inputs.

Top module: `psg_tone_mixer`

## Requirements
- R1: While reset is asserted and right after it, every amplitude is 0. All tone bits start at 0, and the noise register starts at the seed value 1, so the noise bit starts at 1.
- R2: With `full_rate` = 1, every cycle with `clk_en` = 1 is a master tick. With `full_rate` = 0, only every second `clk_en` cycle is one. With `clk_en` = 0, nothing advances.
- R3: Each channel's tone bit inverts once every 8·TP master ticks. TP is that channel's 12-bit slice of `tone_period`, with channel A at bits 11:0, B at 23:12 and C at 35:24. TP = 0 behaves as TP = 1.
- R4: The noise source is a 17-bit shift register seeded with 1. Each step shifts it right and inserts bit0 XOR bit3 at bit 16, and the noise bit is bit 0. It steps once every 16·NP master ticks, where NP is `noise_period`, and NP = 0 behaves as NP = 1.
- R5: `mix_ctl` bits 2:0 disable the tone of channels C,B,A (bit 0 is A). Bits 5:3 disable the noise of channels C,B,A (bit 3 is A). A 1 disables the source and a 0 enables it.
- R6: A channel is audible when (tone bit OR tone disabled) AND (noise bit OR noise disabled). A silent channel outputs 0, and a channel with both sources disabled outputs its level constantly.
- R7: Each channel has a 5-bit `level` slice (A at 4:0). Bit 4 = 0 selects the fixed level L = bits 3:0, which is output as {L,1}. Bit 4 = 1 selects `env_level`.
- R8: The amplitudes are registered. An amplitude reflects the inputs and the tone and noise state present before the clock edge that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Input-clock enable, one pulse per input clock period |
| full_rate | input | 1 | 1: master tick on every enable; 0: on every second enable |
| tone_period | input | 36 | Three 12-bit tone periods, channel A lowest |
| noise_period | input | 5 | Noise period NP |
| mix_ctl | input | 6 | Active-low tone enables in 2:0, noise enables in 5:3 |
| level | input | 15 | Three 5-bit level fields, channel A lowest |
| env_level | input | 5 | Envelope amplitude shared by all channels |
| amp | output | 15 | Three 5-bit amplitudes, channel A lowest |

## Verification
On every cycle, the assertions check the following: the master tick never fires without an enable and never fires twice in a row at half rate. Tone bits move only on the divide-by-8 tick, and the noise register moves only on the divide-by-16 tick and never reaches zero. A muted source forces its channel to 0 one cycle later, and a channel with both sources disabled shows {L,1} or the envelope value. The assertions do not follow the counters, so the exact period lengths are left to the bench. The bench measures 8·TP half-periods at full rate, at half rate and with a gated enable. It also compares all three amplitudes cycle by cycle against an independent model of the prescaler, the tone counters and the noise sequence.

// File: rtl/psg_pkg.sv
package psg_pkg;
    // Amplitude source selected by the top bit of a level field
    typedef enum logic {
        LVL_FIXED = 1'b0,
        LVL_ENV   = 1'b1
    } lvl_src_e;

    localparam int unsigned NOISE_SEED = 1;
endpackage

// File: rtl/psg_timebase.sv
module psg_timebase #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic full_rate,
    output logic mtick,
    output logic tone_tick,
    output logic noise_tick
);
    typedef struct packed {
        logic             phase;
        logic [PRE_W-1:0] pre;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        mtick      = clk_en & (full_rate | st_q.phase);
        tone_tick  = mtick & (&st_q.pre[PRE_W-2:0]);
        noise_tick = mtick & (&st_q.pre);
        if (clk_en) st_d.phase = ~st_q.phase;
        if (mtick)  st_d.pre   = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psg_period_div.sv
module psg_period_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0] eff;
    logic [W:0] inc;

    always_comb begin
        st_d = st_q;
        eff  = (period == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, period};
        inc  = {1'b0, st_q.cnt} + 1'b1;
        wrap = step && (inc >= eff);
        if (step) st_d.cnt = wrap ? '0 : inc[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psg_tone_gen.sv
module psg_tone_gen #(
    parameter int TONE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tone_tick,
    input  logic [TONE_W-1:0] period,
    output logic              tone_bit
);
    logic wrap;
    logic sq_d, sq_q;

    psg_period_div #(.W(TONE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (tone_tick),
        .period (period),
        .wrap   (wrap)
    );

    always_comb sq_d = wrap ? ~sq_q : sq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= 1'b0;
        else        sq_q <= sq_d;
    end

    assign tone_bit = sq_q;
endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen #(
    parameter int NOISE_W = 5,
    parameter int LFSR_W  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               noise_tick,
    input  logic [NOISE_W-1:0] period,
    output logic               noise_bit,
    output logic [LFSR_W-1:0]  state
);
    logic wrap;
    logic [LFSR_W-1:0] sr_d, sr_q;

    psg_period_div #(.W(NOISE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (noise_tick),
        .period (period),
        .wrap   (wrap)
    );

    always_comb begin
        sr_d = sr_q;
        if (wrap) sr_d = {sr_q[0] ^ sr_q[3], sr_q[LFSR_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= LFSR_W'(psg_pkg::NOISE_SEED);
        else        sr_q <= sr_d;
    end

    assign noise_bit = sr_q[0];
    assign state     = sr_q;
endmodule

// File: rtl/psg_chan_out.sv
module psg_chan_out #(
    parameter int AMP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_bit,
    input  logic             noise_bit,
    input  logic             tone_off,
    input  logic             noise_off,
    input  logic [AMP_W-1:0] level,
    input  logic [AMP_W-1:0] env_level,
    output logic [AMP_W-1:0] amp
);
    import psg_pkg::*;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
    } out_state_t;

    out_state_t st_d, st_q;
    logic             audible;
    logic [AMP_W-1:0] picked;

    always_comb begin
        audible = (tone_bit | tone_off) & (noise_bit | noise_off);
        if (lvl_src_e'(level[AMP_W-1]) == LVL_ENV) picked = env_level;
        else                                      picked = {level[AMP_W-2:0], 1'b1};
        st_d.amp = audible ? picked : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign amp = st_q.amp;
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer #(
    parameter int NCH     = 3,
    parameter int TONE_W  = 12,
    parameter int NOISE_W = 5,
    parameter int LFSR_W  = 17,
    parameter int AMP_W   = 5,
    parameter int PRE_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  full_rate,
    input  logic [NCH*TONE_W-1:0] tone_period,
    input  logic [NOISE_W-1:0]    noise_period,
    input  logic [2*NCH-1:0]      mix_ctl,
    input  logic [NCH*AMP_W-1:0]  level,
    input  logic [AMP_W-1:0]      env_level,
    output logic [NCH*AMP_W-1:0]  amp
);
    logic              mtick;
    logic              tick8;
    logic              tick16;
    logic [NCH-1:0]    tone_bits;
    logic              noise_bit;
    logic [LFSR_W-1:0] lfsr_state;

    psg_timebase #(.PRE_W(PRE_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .full_rate  (full_rate),
        .mtick      (mtick),
        .tone_tick  (tick8),
        .noise_tick (tick16)
    );

    psg_noise_gen #(.NOISE_W(NOISE_W), .LFSR_W(LFSR_W)) u_noise (
        .clk        (clk),
        .rst_n      (rst_n),
        .noise_tick (tick16),
        .period     (noise_period),
        .noise_bit  (noise_bit),
        .state      (lfsr_state)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        psg_tone_gen #(.TONE_W(TONE_W)) u_tone (
            .clk       (clk),
            .rst_n     (rst_n),
            .tone_tick (tick8),
            .period    (tone_period[ch*TONE_W +: TONE_W]),
            .tone_bit  (tone_bits[ch])
        );

        psg_chan_out #(.AMP_W(AMP_W)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .tone_bit  (tone_bits[ch]),
            .noise_bit (noise_bit),
            .tone_off  (mix_ctl[ch]),
            .noise_off (mix_ctl[NCH+ch]),
            .level     (level[ch*AMP_W +: AMP_W]),
            .env_level (env_level),
            .amp       (amp[ch*AMP_W +: AMP_W])
        );
    end
endmodule

// File: rtl/psg_tone_mixer_chk.sv
module psg_tone_mixer_chk #(
    parameter int NCH    = 3,
    parameter int LFSR_W = 17,
    parameter int AMP_W  = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clk_en,
    input logic                 full_rate,
    input logic [2*NCH-1:0]     mix_ctl,
    input logic [NCH*AMP_W-1:0] level,
    input logic [AMP_W-1:0]     env_level,
    input logic [NCH*AMP_W-1:0] amp,
    input logic                 mtick,
    input logic                 tick8,
    input logic                 tick16,
    input logic [NCH-1:0]       tone_bits,
    input logic                 noise_bit,
    input logic [LFSR_W-1:0]    lfsr_state
);
    assert_no_tick_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !mtick)
        else $error("R2 master tick without enable");

    assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mtick && !full_rate) |=> (!mtick || full_rate))
        else $error("R2 back-to-back ticks at half rate");

    assert_tone_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick8 |=> $stable(tone_bits))
        else $error("R3 tone moved off its tick");

    assert_noise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(lfsr_state))
        else $error("R4 noise moved off its tick");

    assert_noise_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0)
        else $error("R4 noise register stuck at zero");

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_tone_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mix_ctl[ch] && !tone_bits[ch]) |=> amp[ch*AMP_W +: AMP_W] == '0)
            else $error("R6 muted by tone but not silent");

        assert_noise_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mix_ctl[NCH+ch] && !noise_bit) |=> amp[ch*AMP_W +: AMP_W] == '0)
            else $error("R6 muted by noise but not silent");

        assert_fixed_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mix_ctl[ch] && mix_ctl[NCH+ch] && !level[ch*AMP_W+AMP_W-1])
            |=> amp[ch*AMP_W +: AMP_W] == {$past(level[ch*AMP_W +: AMP_W-1]), 1'b1})
            else $error("R7 fixed level mapping wrong");

        assert_env_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mix_ctl[ch] && mix_ctl[NCH+ch] && level[ch*AMP_W+AMP_W-1])
            |=> amp[ch*AMP_W +: AMP_W] == $past(env_level))
            else $error("R7 envelope level not passed");
    end
endmodule

bind psg_tone_mixer psg_tone_mixer_chk #(.NCH(NCH), .LFSR_W(LFSR_W), .AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .full_rate  (full_rate),
    .mix_ctl    (mix_ctl),
    .level      (level),
    .env_level  (env_level),
    .amp        (amp),
    .mtick      (mtick),
    .tick8      (tick8),
    .tick16     (tick16),
    .tone_bits  (tone_bits),
    .noise_bit  (noise_bit),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_psg_tone_mixer.sv
module tb_psg_tone_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        full_rate = 1'b1;
    logic [35:0] tone_period = '0;
    logic [4:0]  noise_period = '0;
    logic [5:0]  mix_ctl = 6'h3F;
    logic [14:0] level = '0;
    logic [4:0]  env_level = '0;
    logic [14:0] amp;

    int n_chk = 0;
    int n_bad = 0;
    logic gate_mode = 1'b0;

    psg_tone_mixer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .full_rate    (full_rate),
        .tone_period  (tone_period),
        .noise_period (noise_period),
        .mix_ctl      (mix_ctl),
        .level        (level),
        .env_level    (env_level),
        .amp          (amp)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int ch_amp(int ch);
        return int'(amp[ch*5 +: 5]);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one clock, then sample away from the edge; gated enable alternates
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (gate_mode) clk_en = ~clk_en;
        else           clk_en = 1'b1;
    endtask

    task automatic test_reset();
        mix_ctl = 6'h3F;
        level = {5'd0, 5'd0, 5'd5};
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 amp A in reset", ch_amp(0), 0);
        check("R1 amp C in reset", ch_amp(2), 0);
        rst_n = 1'b1;
        step();
        check("R1 amp A first cycle", ch_amp(0), 11);
    endtask

    task automatic test_fixed();
        mix_ctl = 6'h3F;
        level = {5'd15, 5'd0, 5'd5};
        step(); step();
        check("R7 fixed A L=5", ch_amp(0), 11);
        check("R7 fixed B L=0", ch_amp(1), 1);
        check("R7 fixed C L=15", ch_amp(2), 31);
    endtask

    task automatic test_envelope();
        mix_ctl = 6'h3F;
        level = {5'd3, 5'b10000, 5'b11111};
        env_level = 5'd17;
        step(); step();
        check("R7 env B", ch_amp(1), 17);
        check("R7 env A ignores L", ch_amp(0), 17);
        check("R7 fixed C beside env", ch_amp(2), 7);
        env_level = 5'd4;
        check("R8 before edge", ch_amp(1), 17);
        step();
        check("R8 after one edge", ch_amp(1), 4);
    endtask

    task automatic measure(int ch, int exp, string req);
        int prev;
        int len;
        bit seen;
        prev = ch_amp(ch);
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            step();
            if (ch_amp(ch) != prev) seen = 1;
        end
        prev = ch_amp(ch);
        len = 0;
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            step();
            len++;
            if (ch_amp(ch) != prev) seen = 1;
        end
        check(req, len, exp);
    endtask

    task automatic test_tone_periods();
        mix_ctl = 6'b111000;
        level = {5'd15, 5'd15, 5'd15};
        full_rate = 1'b1;
        gate_mode = 1'b0;
        tone_period = {12'd300, 12'd0, 12'd3};
        do_reset();
        measure(0, 24, "R3 TP=3 half period");
        measure(0, 24, "R3 TP=3 second half");
        measure(1, 8, "R3 TP=0 as 1");
        measure(2, 2400, "R3 TP=300");
        tone_period[11:0] = 12'd1;
        measure(0, 8, "R3 TP=1 after change");
    endtask

    task automatic test_rates();
        full_rate = 1'b0;
        measure(0, 16, "R2 half rate");
        full_rate = 1'b1;
        gate_mode = 1'b1;
        measure(0, 16, "R2 gated enable");
        full_rate = 1'b0;
        measure(0, 32, "R2 gated half rate");
        gate_mode = 1'b0;
        full_rate = 1'b1;
        clk_en = 1'b0;
        begin
            int held;
            held = ch_amp(0);
            repeat (40) begin
                @(posedge clk);
                @(negedge clk);
            end
            check("R2 no enable no change", ch_amp(0), held);
        end
        clk_en = 1'b1;
    endtask

    task automatic test_model();
        logic [16:0] s;
        logic nb [0:31];
        int tone_a;
        int tone_c;
        int nz;
        int t8;
        int ea;
        int eb;
        int ec;
        s = 17'd1;
        for (int k = 0; k < 32; k++) begin
            nb[k] = s[0];
            s = {s[0] ^ s[3], s[16:1]};
        end
        full_rate = 1'b1;
        gate_mode = 1'b0;
        clk_en = 1'b1;
        tone_period = {12'd2, 12'd7, 12'd1};
        noise_period = 5'd0;
        mix_ctl = 6'b100_010;
        level = {5'd0, 5'b10000, 5'd9};
        env_level = 5'd22;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 1; n <= 300; n++) begin
            @(posedge clk);
            @(negedge clk);
            t8 = (n - 1) / 8;
            tone_a = t8 % 2;
            tone_c = (t8 / 2) % 2;
            nz = int'(nb[(n - 1) / 16]);
            ea = (tone_a == 1 && nz == 1) ? 19 : 0;
            eb = (nz == 1) ? 22 : 0;
            ec = (tone_c == 1) ? 1 : 0;
            if (n % 4 == 0) begin
                check("R6 A tone AND noise", ch_amp(0), ea);
                check("R4 B noise only", ch_amp(1), eb);
                check("R5 C tone only", ch_amp(2), ec);
            end
        end
    endtask

    initial begin
        do_reset();
        test_reset();
        test_fixed();
        test_envelope();
        test_tone_periods();
        test_rates();
        test_model();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule